// File: doc/BRIEF.md
# Byte-Addressed SRAM Controller with Posted Write

This block connects a simple processor-side request bus to a single-port synchronous RAM array. The bus carries 8-bit, 16-bit and 32-bit accesses on a byte-addressed space. The controller forces natural alignment: it drops the low address bits that the access size does not use. It derives byte-lane enables from the size and the remaining low address bits. It copies write data across the lanes, and it right-justifies and zero-extends narrow read data.

Writes never stall. Each write goes into a one-entry buffer and reaches the array only when the next write arrives, at which point the new write takes the buffer's place. Reads see the buffered bytes merged over the array word. A reset empties the buffer without committing it, so a write that is still pending at reset is lost. Software protects its last write by writing again, or by pulsing the flush input, which commits the pending entry without a new write.

Top module: `sram_posted_ctrl`

## Requirements
- R1: After reset, `buf_busy` and `rsp_valid` are both low.
- R2: A byte access (size code 0) uses lane `addr[1:0]`, where lane n is bits 8n+7..8n of the little-endian word. The read result is that byte in bits 7..0, with bits 31..8 zero.
- R3: A halfword access (size code 1) ignores `addr[0]` and uses bits 31..16 when `addr[1]` is 1 and bits 15..0 otherwise. The read result is right-justified and zero-extended.
- R4: A word access (size codes 2 and 3) ignores `addr[1:0]` and uses all four lanes.
- R5: A read request is answered exactly one cycle later, with `rsp_valid` high for that one cycle only. `rsp_valid` is low in every cycle that does not follow a read request.
- R6: A write is accepted in every cycle, including back-to-back cycles, and `buf_busy` is high in the cycle after any write.
- R7: A read of the word held in the buffer returns the buffered bytes in the lanes that were written and array data in the other lanes.
- R8: A buffered write is committed to the array when the next write arrives, so it survives a later reset. This holds also when the next write is the same write repeated.
- R9: Reset discards a pending buffered write: after reset, a read of that word returns what the array held before that write.
- R10: A `flush` pulse with a buffered entry and no write commits the entry and clears `buf_busy` in the next cycle. A `flush` in the same cycle as a write has the same effect as the write alone.
- R11: Capacity is set by `CAP_KB` (8, 16 or 32). The address is log2(CAP_KB*1024) bits wide, and the topmost word is fully usable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; does not clear the array |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_addr | input | log2(CAP_KB*1024) | Byte address |
| req_wdata | input | 32 | Write data, right-justified |
| flush | input | 1 | Commit the pending buffered write |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, right-justified and zero-extended |
| buf_busy | output | 1 | Write buffer holds an uncommitted entry |

## Verification
The bench builds the block with the default `CAP_KB` of 8, which gives a 13-bit address and a 2048-word array. At this size the topmost word at 0x1FFC can be reached, which tests the full index width. Reset is pulsed in the middle of the run while the array keeps its contents. This makes lost and surviving writes visible through ordinary reads: the reset-discard path, double-write persistence and flush persistence are all checked this way.

// File: rtl/sram_posted_ctrl.sv
module sram_posted_ctrl #(
  parameter int CAP_KB = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 req_valid,
  input  logic                                 req_write,
  input  logic [1:0]                           req_size,
  input  logic [$clog2(CAP_KB*1024)-1:0]       req_addr,
  input  logic [31:0]                          req_wdata,
  input  logic                                 flush,
  output logic                                 rsp_valid,
  output logic [31:0]                          rsp_rdata,
  output logic                                 buf_busy
);
  localparam int BYTES = CAP_KB * 1024;
  localparam int AW    = $clog2(BYTES);
  localparam int WORDS = BYTES / 4;
  localparam int IW    = AW - 2;

  logic [31:0] mem [WORDS];

  wire          wr  = req_valid & req_write;
  wire          rd  = req_valid & ~req_write;
  wire [IW-1:0] idx = req_addr[AW-1:2];

  logic [3:0]  lane_be;
  logic [31:0] lane_dat;

  always_comb begin
    case (req_size)
      2'd0: begin
        lane_be  = 4'b0001 << req_addr[1:0];
        lane_dat = {4{req_wdata[7:0]}};
      end
      2'd1: begin
        lane_be  = req_addr[1] ? 4'b1100 : 4'b0011;
        lane_dat = {2{req_wdata[15:0]}};
      end
      default: begin
        lane_be  = 4'b1111;
        lane_dat = req_wdata;
      end
    endcase
  end

  logic          buf_v;
  logic [IW-1:0] buf_idx;
  logic [3:0]    buf_be;
  logic [31:0]   buf_dat;

  wire commit = buf_v & (wr | flush);

  always_ff @(posedge clk) begin
    if (!rst_n) buf_v <= 1'b0;
    else if (wr) buf_v <= 1'b1;
    else if (flush) buf_v <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (wr) begin
      buf_idx <= idx;
      buf_be  <= lane_be;
      buf_dat <= lane_dat;
    end
  end

  assign buf_busy = buf_v;

  logic [31:0] arr_q;

  always_ff @(posedge clk) begin
    if (commit)
      for (int i = 0; i < 4; i++)
        if (buf_be[i]) mem[buf_idx][8*i +: 8] <= buf_dat[8*i +: 8];
    if (rd) arr_q <= mem[idx];
  end

  logic        rv_q;
  logic [3:0]  hit_be_q;
  logic [31:0] hit_dat_q;
  logic [1:0]  off_q;
  logic [1:0]  size_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rv_q <= 1'b0;
    else rv_q <= rd;
  end

  always_ff @(posedge clk) begin
    if (rd) begin
      hit_be_q  <= (buf_v && buf_idx == idx) ? buf_be : 4'b0000;
      hit_dat_q <= buf_dat;
      off_q     <= req_addr[1:0];
      size_q    <= req_size;
    end
  end

  logic [31:0] merged;
  always_comb
    for (int i = 0; i < 4; i++)
      merged[8*i +: 8] = hit_be_q[i] ? hit_dat_q[8*i +: 8] : arr_q[8*i +: 8];

  logic [31:0] b_shift, h_shift;
  assign b_shift = merged >> {off_q, 3'b000};
  assign h_shift = merged >> {off_q[1], 4'b0000};

  assign rsp_valid = rv_q;
  assign rsp_rdata = (size_q == 2'd0) ? {24'h0, b_shift[7:0]}  :
                     (size_q == 2'd1) ? {16'h0, h_shift[15:0]} : merged;

  p_busy_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> buf_busy);
  p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !wr) |=> !buf_busy);
  p_rsp_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);
  p_no_spurious_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rsp_valid);
  p_byte_one_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_size == 2'd0) |=> $countones(buf_be) == 1);
  p_word_all_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_size[1]) |=> buf_be == 4'b1111);
  p_buffer_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_v && !wr && !flush) |=> (buf_busy && $stable(buf_idx) && $stable(buf_dat)));
endmodule

// File: tb/tb_sram_posted_ctrl.sv
module tb_sram_posted_ctrl;
  localparam int AW = 13;
  localparam int NV = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, flush = 1'b0;
  logic [1:0] req_size = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, buf_busy;
  logic [31:0] rsp_rdata;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sram_posted_ctrl #(.CAP_KB(8)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .flush(flush), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .buf_busy(buf_busy)
  );

  // {write, size, addr[15:0], wdata, expected read data}
  localparam logic [82:0] VEC [NV] = '{
    {1'b1, 2'd2, 16'h0100, 32'hDEADBEEF, 32'h0},
    {1'b1, 2'd2, 16'h0104, 32'h01234567, 32'h0},
    {1'b0, 2'd2, 16'h0102, 32'h0, 32'hDEADBEEF},  // R4
    {1'b0, 2'd0, 16'h0101, 32'h0, 32'h000000BE},  // R2
    {1'b0, 2'd1, 16'h0103, 32'h0, 32'h0000DEAD},  // R3
    {1'b0, 2'd3, 16'h0107, 32'h0, 32'h01234567},  // R7 full hit, R4
    {1'b1, 2'd0, 16'h0102, 32'h000000A5, 32'h0},
    {1'b0, 2'd2, 16'h0100, 32'h0, 32'hDEA5BEEF},  // R7 byte merge
    {1'b1, 2'd1, 16'h0106, 32'h0000CAFE, 32'h0},
    {1'b0, 2'd2, 16'h0104, 32'h0, 32'hCAFE4567},  // R7 half merge
    {1'b0, 2'd1, 16'h0104, 32'h0, 32'h00004567},  // R3
    {1'b1, 2'd2, 16'h1FFC, 32'h0BADF00D, 32'h0},
    {1'b0, 2'd2, 16'h1FFD, 32'h0, 32'h0BADF00D},  // R11
    {1'b0, 2'd0, 16'h1FFF, 32'h0, 32'h0000000B}   // R11, R2
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] sz, input logic [AW-1:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_size = sz; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] sz, input logic [AW-1:0] a,
                         input logic [31:0] exp, input string tag);
    req_valid = 1'b1; req_write = 1'b0; req_size = sz; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " rsp_valid"}, {31'h0, rsp_valid}, 32'h1);
    check({tag, " data"}, rsp_rdata, exp);
  endtask

  task automatic pulse_reset();
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 busy", {31'h0, buf_busy}, 32'h0);
    check("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [82:0] v;
      v = VEC[i];
      req_valid = 1'b1; req_write = v[82]; req_size = v[81:80];
      req_addr = v[64+AW-1:64]; req_wdata = v[63:32];
      @(negedge clk);
      if (v[82]) check($sformatf("R6 busy vec%0d", i), {31'h0, buf_busy}, 32'h1);
      else begin
        check($sformatf("R5 valid vec%0d", i), {31'h0, rsp_valid}, 32'h1);
        check($sformatf("R2/R3/R4/R7/R11 data vec%0d", i), rsp_rdata, v[31:0]);
      end
    end
    req_valid = 1'b0; req_write = 1'b0;
    @(negedge clk);
    check("R5 no response after idle", {31'h0, rsp_valid}, 32'h0);

    // R9 lost pending write, R8 committed write survives
    do_write(2'd2, 13'h0300, 32'h11111111);
    do_write(2'd2, 13'h0304, 32'h22222222);
    do_write(2'd2, 13'h0300, 32'h33333333);
    check("R5 no response after write", {31'h0, rsp_valid}, 32'h0);
    pulse_reset();
    check("R1 busy after reset", {31'h0, buf_busy}, 32'h0);
    do_read(2'd2, 13'h0300, 32'h11111111, "R9");
    do_read(2'd2, 13'h0304, 32'h22222222, "R8");

    // R8 the same write twice persists
    do_write(2'd2, 13'h0308, 32'h44444444);
    do_write(2'd2, 13'h0308, 32'h44444444);
    pulse_reset();
    do_read(2'd2, 13'h0308, 32'h44444444, "R8 double");

    // R10 flush commits and clears busy
    do_write(2'd2, 13'h0200, 32'h55AA55AA);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    check("R10 busy after flush", {31'h0, buf_busy}, 32'h0);
    pulse_reset();
    do_read(2'd2, 13'h0200, 32'h55AA55AA, "R10 flushed");

    // R10 flush with write behaves as the write
    do_write(2'd2, 13'h0210, 32'h00000001);
    flush = 1'b1;
    do_write(2'd2, 13'h0214, 32'h00000002);
    flush = 1'b0;
    check("R10 busy after flush+write", {31'h0, buf_busy}, 32'h1);
    pulse_reset();
    do_read(2'd2, 13'h0210, 32'h00000001, "R10 flush+write");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule